// File: doc/BRIEF.md
# Load/Store Effective Address Generator with Pointer Masking

This block forms the effective address for a load or store. It adds a sign-extended 12-bit offset to a 64-bit register operand. It then puts the sum into canonical form for the current operating width, and can apply an address-masking step and a base-insertion step. A register operand whose index is zero reads as zero, whatever value is on the operand bus. The address is registered, so the result appears one clock after the request, together with a valid flag.

Two enables, a 64-bit mask and a 64-bit base are held in configuration registers, which a single write strobe loads together. The steps run in a fixed order: the add, then masking or 32-bit zero-extension, then the base OR. In 32-bit mode the zero-extension applies only while masking is off, so an enabled mask has full control over the upper bits.

Top module: `agu_ptrmask`

## Requirements
- R1: In 64-bit mode (`mode_w32`=0) with both enables clear, `out_addr` equals the operand plus the sign-extended immediate (bit 11 is the sign), taken modulo 2^64.
- R2: When `rs_idx` is 0, the operand is taken as zero and `rs_val` has no effect on `out_addr`.
- R3: With the mask enable set, the sum is ANDed bitwise with the mask register before any base step.
- R4: In 32-bit mode (`mode_w32`=1) with the mask enable clear, bits 63:32 of the sum are forced to zero and bits 31:0 pass through.
- R5: In 32-bit mode with the mask enable set, no zero-extension takes place, and the upper bits are exactly the upper bits of the sum ANDed with the mask.
- R6: With the base enable set, the base register is ORed into the address after the mask step or the zero-extension step, so every base bit is 1 in the result even where the mask cleared it.
- R7: `out_valid` equals `in_valid` delayed by exactly one clock, and `out_addr` for a request is visible in the cycle that follows it. Back-to-back requests each produce their own result.
- R8: While `in_valid` is low, `out_addr` keeps its last value.
- R9: After reset both enables are clear, `out_valid` is 0 and `out_addr` is 0.
- R10: A configuration write (`cfg_wr`=1) takes effect from the next cycle. A request presented in the same cycle as the write uses the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Loads the four configuration fields below |
| cfg_mask_en | input | 1 | Mask enable value to load |
| cfg_base_en | input | 1 | Base enable value to load |
| cfg_mask | input | 64 | Mask value to load |
| cfg_base | input | 64 | Base value to load |
| in_valid | input | 1 | Request present |
| rs_idx | input | 5 | Index of the register operand; 0 selects zero |
| rs_val | input | 64 | Value of the register operand |
| imm | input | 12 | Signed offset |
| mode_w32 | input | 1 | 1 = 32-bit operating width, 0 = 64-bit |
| out_valid | output | 1 | Result valid, one clock after the request |
| out_addr | output | 64 | Registered effective address |

## Verification
The add is tried with positive and negative offsets, with a carry that wraps past 2^64, and with a carry out of bit 31. The carry case shows whether 32-bit zero-extension is applied. Requests with index 0 carry a non-zero operand value, so a design that reads the bus where it should use zero gives a different address. Mask and base values are chosen so that the mask clears bits the base then sets, which exposes a wrong order of the two steps. A 32-bit request with masking on carries a sum with upper bits set, so a design that also zero-extends in that case is caught. A configuration write issued in the same cycle as a request separates old-configuration use from new-configuration use.

// File: rtl/agu_ptrmask.sv
module agu_ptrmask #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 12,
  parameter int IDX_W = 5,
  parameter int LOW_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_mask_en,
  input  logic             cfg_base_en,
  input  logic [XLEN-1:0]  cfg_mask,
  input  logic [XLEN-1:0]  cfg_base,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] rs_idx,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [IMM_W-1:0] imm,
  input  logic             mode_w32,
  output logic             out_valid,
  output logic [XLEN-1:0]  out_addr
);
  localparam int EXT_W = XLEN - IMM_W;
  localparam int HI_W  = XLEN - LOW_W;

  logic            mask_en_q, base_en_q;
  logic [XLEN-1:0] mask_q, base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_en_q <= 1'b0;
      base_en_q <= 1'b0;
      mask_q    <= '0;
      base_q    <= '0;
    end else if (cfg_wr) begin
      mask_en_q <= cfg_mask_en;
      base_en_q <= cfg_base_en;
      mask_q    <= cfg_mask;
      base_q    <= cfg_base;
    end
  end

  logic [XLEN-1:0] opnd, imm_x, sum, canon, eff;

  assign opnd  = (rs_idx == '0) ? '0 : rs_val;
  assign imm_x = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign sum   = opnd + imm_x;

  always_comb begin
    if (mask_en_q)
      canon = sum & mask_q;
    else if (mode_w32)
      canon = {{HI_W{1'b0}}, sum[LOW_W-1:0]};
    else
      canon = sum;
  end

  assign eff = base_en_q ? (canon | base_q) : canon;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_addr <= eff;
    end
  end
endmodule

// File: rtl/agu_ptrmask_chk.sv
module agu_ptrmask_chk #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 12,
  parameter int IDX_W = 5,
  parameter int LOW_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [IDX_W-1:0] rs_idx,
  input logic [IMM_W-1:0] imm,
  input logic             mode_w32,
  input logic             mask_en_q,
  input logic             base_en_q,
  input logic [XLEN-1:0]  mask_q,
  input logic [XLEN-1:0]  base_q,
  input logic             out_valid,
  input logic [XLEN-1:0]  out_addr
);
  // R7
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R7
  idle_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_addr));
  // R3
  mask_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_en_q) |=> ((out_addr & ~($past(mask_q) | $past(base_q))) == '0));
  // R6
  base_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && base_en_q) |=> ((out_addr & $past(base_q)) == $past(base_q)));
  // R4
  zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_w32 && !mask_en_q && !base_en_q) |=> (out_addr[XLEN-1:LOW_W] == '0));
  // R2
  zero_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rs_idx == '0 && !mode_w32 && !mask_en_q && !base_en_q)
      |=> (out_addr == $past({{(XLEN-IMM_W){imm[IMM_W-1]}}, imm})));
endmodule

bind agu_ptrmask agu_ptrmask_chk #(.XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W), .LOW_W(LOW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rs_idx(rs_idx), .imm(imm),
  .mode_w32(mode_w32), .mask_en_q(mask_en_q), .base_en_q(base_en_q),
  .mask_q(mask_q), .base_q(base_q), .out_valid(out_valid), .out_addr(out_addr)
);

// File: tb/agu_ptrmask_test.sv
`timescale 1ns/1ps
module agu_ptrmask_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_mask_en = 1'b0, cfg_base_en = 1'b0;
  logic [63:0] cfg_mask = '0, cfg_base = '0;
  logic        in_valid = 1'b0;
  logic [4:0]  rs_idx = '0;
  logic [63:0] rs_val = '0;
  logic [11:0] imm = '0;
  logic        mode_w32 = 1'b0;
  logic        out_valid;
  logic [63:0] out_addr;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  agu_ptrmask uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mask_en(cfg_mask_en),
    .cfg_base_en(cfg_base_en), .cfg_mask(cfg_mask), .cfg_base(cfg_base),
    .in_valid(in_valid), .rs_idx(rs_idx), .rs_val(rs_val), .imm(imm),
    .mode_w32(mode_w32), .out_valid(out_valid), .out_addr(out_addr)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_cfg(bit men, bit ben, logic [63:0] m, logic [63:0] b);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_mask_en = men; cfg_base_en = ben; cfg_mask = m; cfg_base = b;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic issue(string req, logic [4:0] idx, logic [63:0] v, logic [11:0] im,
                       bit w32, logic [63:0] exp);
    @(negedge clk);
    in_valid = 1'b1; rs_idx = idx; rs_val = v; imm = im; mode_w32 = w32;
    @(posedge clk); #1;
    check(req, {63'd0, out_valid}, 64'd1);
    check(req, out_addr, exp);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R9 out_valid", {63'd0, out_valid}, 64'd0);
    check("R9 out_addr", out_addr, 64'd0);
    issue("R9 enables clear", 5'd3, 64'h0000_0000_0000_1000, 12'h000, 1'b0, 64'h1000);
  endtask

  task automatic t_add;
    issue("R1 positive imm", 5'd1, 64'h1234_5678_9abc_def0, 12'h7ff, 1'b0, 64'h1234_5678_9abc_e6ef);
    issue("R1 negative imm", 5'd2, 64'h0000_0000_0000_1000, 12'h800, 1'b0, 64'h0000_0000_0000_0800);
    issue("R1 wrap", 5'd4, 64'hffff_ffff_ffff_ffff, 12'h001, 1'b0, 64'h0);
    issue("R1 carry bit31 64-bit", 5'd5, 64'h0000_0001_ffff_fff0, 12'h020, 1'b0, 64'h0000_0002_0000_0010);
  endtask

  task automatic t_zero_idx;
    issue("R2 idx0 pos", 5'd0, 64'hdead_beef_0000_0000, 12'h005, 1'b0, 64'h5);
    issue("R2 idx0 neg", 5'd0, 64'h0000_0000_0000_1234, 12'hfff, 1'b0, 64'hffff_ffff_ffff_ffff);
  endtask

  task automatic t_mode32;
    issue("R4 zext", 5'd5, 64'h0000_0001_ffff_fff0, 12'h020, 1'b1, 64'h0000_0000_0000_0010);
    issue("R4 neg imm", 5'd6, 64'h0000_0000_0000_0000, 12'hffe, 1'b1, 64'h0000_0000_ffff_fffe);
  endtask

  task automatic t_mask;
    set_cfg(1'b1, 1'b0, 64'h00ff_ffff_ffff_ffff, 64'h0);
    issue("R3 mask top byte", 5'd7, 64'hab00_0000_0000_1000, 12'h004, 1'b0, 64'h0000_0000_0000_1004);
    issue("R5 mask in 32-bit", 5'd8, 64'h0000_0005_0000_0000, 12'h008, 1'b1, 64'h0000_0005_0000_0008);
  endtask

  task automatic t_base;
    set_cfg(1'b1, 1'b1, 64'h0000_0000_ffff_ffff, 64'h8000_0000_0000_0000);
    issue("R6 mask then base", 5'd9, 64'h1234_0000_0000_0040, 12'hfc0, 1'b0, 64'h8000_0000_0000_0000);
    set_cfg(1'b0, 1'b1, 64'h0, 64'h8000_0000_0000_0000);
    issue("R6 zext then base", 5'd10, 64'hffff_0000_1000_0000, 12'h000, 1'b1, 64'h8000_0000_1000_0000);
    set_cfg(1'b0, 1'b0, 64'h0, 64'h0);
  endtask

  task automatic t_valid;
    issue("R7 single", 5'd11, 64'h100, 12'h010, 1'b0, 64'h110);
    @(posedge clk); #1;
    check("R7 drops", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    rs_idx = 5'd12; rs_val = 64'hffff; imm = 12'h001;
    @(posedge clk); #1;
    check("R8 hold", out_addr, 64'h110);
    @(negedge clk);
    in_valid = 1'b1; rs_idx = 5'd1; rs_val = 64'h200; imm = 12'h001;
    @(negedge clk);
    check("R7 first b2b", out_addr, 64'h201);
    rs_val = 64'h300; imm = 12'h002;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 second b2b", out_addr, 64'h302);
    check("R7 b2b valid", {63'd0, out_valid}, 64'd1);
  endtask

  task automatic t_cfg_timing;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_mask_en = 1'b1; cfg_base_en = 1'b0; cfg_mask = 64'h0; cfg_base = 64'h0;
    in_valid = 1'b1; rs_idx = 5'd3; rs_val = 64'h4000; imm = 12'h000; mode_w32 = 1'b0;
    @(negedge clk);
    cfg_wr = 1'b0;
    check("R10 old cfg used", out_addr, 64'h4000);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 new cfg used", out_addr, 64'h0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_add();
    t_zero_idx();
    t_mode32();
    t_mask();
    t_base();
    t_valid();
    t_cfg_timing();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule